// File: doc/BRIEF.md
# Temperature Monitor Register Bank

This block is the register file of a digital temperature monitor. It holds eight 16-bit registers at a 3-bit address: a constant capability word, the configuration word, three temperature limits (high, low and critical), the temperature data word, and two constant identification words. Writes are applied on the clock edge. Reads are combinational from the current address.

The block enforces the per-bit write rules. Two sticky lock bits in the configuration word are cleared only by the power-on reset. One lock protects the critical limit and the other protects the high and low limits. While either lock is set, most configuration fields are frozen. Shutdown may then be cleared but not set.

The limit registers hold only quarter-degree resolution. The clear-event bit acts as a write strobe and never stores a value. The event status bit comes from the event logic. The temperature data word combines the trip status bits, which the comparator drives, with the last captured 13-bit sample. That sample is held while shutdown is set. The decoded configuration fields and the three limits are brought out for the conversion and event logic.

Top module: `tsense_regbank`

## Requirements
- R1: After reset the reads are as follows: address 0 reads 005Fh, address 6 reads 1B09h, address 7 reads 0812h, and addresses 1 to 5 read 0000h when the trip and event status inputs are 0.
- R2: A write to address 0, 5, 6 or 7 changes no read value.
- R3: In a configuration read (address 1), bits 15:11 and bit 5 always read 0. Bit 4 reads the `evt_status_i` input and never the write data.
- R4: A configuration write with bit 5 set raises `clr_evt_o` for exactly the one cycle that follows the write edge.
- R5: Limit registers (address 2 high, 3 low, 4 critical) read bits 15:13 and 1:0 as 0. Bits 12:2 read back as written.
- R6: Configuration bit 7 (critical lock) and bit 6 (alarm lock) are set by writing 1. Once set, they stay set until reset, whatever is written.
- R7: While the critical lock is set, writes to the critical limit are ignored. While the alarm lock is set, writes to the high and low limits are ignored.
- R8: While either lock is set, the following bits keep their value: hysteresis (bits 10:9), output enable (bit 3), polarity (bit 1) and interrupt mode (bit 0).
- R9: Shutdown (bit 8) cannot go from 0 to 1 while either lock is set. Writing 0 to it clears it at any time.
- R10: Critical-only (bit 2) cannot be set while the alarm lock is set.
- R11: The temperature data read (address 5) places `trip_i[2:0]` (critical, high, low) in bits 15:13 and the last captured sample in bits 12:0. A sample is captured on a `sample_vld_i` cycle only while shutdown is clear.
- R12: The decoded configuration outputs equal the stored configuration fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data of the addressed register |
| sample_vld_i | input | 1 | New conversion result present |
| sample_i | input | 13 | Two's-complement temperature sample |
| trip_i | input | 3 | Trip status {critical, high, low} |
| evt_status_i | input | 1 | Current event output state |
| hyst_o | output | 2 | Hysteresis select |
| shdn_o | output | 1 | Shutdown request |
| crit_lock_o | output | 1 | Critical lock state |
| alarm_lock_o | output | 1 | Alarm lock state |
| clr_evt_o | output | 1 | One-cycle clear-event strobe |
| evt_oe_o | output | 1 | Event output enable |
| crit_only_o | output | 1 | Event on critical limit only |
| evt_pol_o | output | 1 | Event polarity, 1 = active high |
| irq_mode_o | output | 1 | Interrupt mode, 0 = comparator |
| hi_lim_o | output | 16 | High limit register value |
| lo_lim_o | output | 16 | Low limit register value |
| crit_lim_o | output | 16 | Critical limit register value |

## Verification
A lock bit that drops without a reset shows up at the next write: a frozen field or limit would then change, and it shows directly on `crit_lock_o` or `alarm_lock_o` on the following cycle. A missed shutdown gate shows as a new sample in the data read one cycle after `sample_vld_i`. A masking fault shows as nonzero reserved or fractional bits in the first read that follows the write. A stuck clear strobe shows on `clr_evt_o` one cycle after the write that should have ended it.

// File: rtl/tsense_regbank.sv
module tsense_regbank #(
  parameter logic [15:0] CAP_VAL = 16'h005F,
  parameter logic [15:0] MFR_VAL = 16'h1B09,
  parameter logic [15:0] DEV_VAL = 16'h0812,
  parameter int          SMP_W   = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [2:0]       addr_i,
  input  logic [15:0]      wdata_i,
  output logic [15:0]      rdata_o,
  input  logic             sample_vld_i,
  input  logic [SMP_W-1:0] sample_i,
  input  logic [2:0]       trip_i,
  input  logic             evt_status_i,
  output logic [1:0]       hyst_o,
  output logic             shdn_o,
  output logic             crit_lock_o,
  output logic             alarm_lock_o,
  output logic             clr_evt_o,
  output logic             evt_oe_o,
  output logic             crit_only_o,
  output logic             evt_pol_o,
  output logic             irq_mode_o,
  output logic [15:0]      hi_lim_o,
  output logic [15:0]      lo_lim_o,
  output logic [15:0]      crit_lim_o
);
  localparam int LIM_W = 11;

  logic [1:0]       hyst_q;
  logic             shdn_q, clk_q, alk_q, clr_q, oe_q, conly_q, pol_q, mode_q;
  logic [LIM_W-1:0] hi_q, lo_q, cr_q;
  logic [SMP_W-1:0] smp_q;

  wire locked = clk_q | alk_q;
  wire wr_cfg = wr_en_i && (addr_i == 3'd1);
  wire wr_hi  = wr_en_i && (addr_i == 3'd2) && !alk_q;
  wire wr_lo  = wr_en_i && (addr_i == 3'd3) && !alk_q;
  wire wr_cr  = wr_en_i && (addr_i == 3'd4) && !clk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hyst_q  <= '0;
      shdn_q  <= 1'b0;
      clk_q   <= 1'b0;
      alk_q   <= 1'b0;
      clr_q   <= 1'b0;
      oe_q    <= 1'b0;
      conly_q <= 1'b0;
      pol_q   <= 1'b0;
      mode_q  <= 1'b0;
    end else begin
      clr_q <= wr_cfg & wdata_i[5];
      if (wr_cfg) begin
        clk_q <= clk_q | wdata_i[7];
        alk_q <= alk_q | wdata_i[6];
        if (!locked) begin
          hyst_q <= wdata_i[10:9];
          oe_q   <= wdata_i[3];
          pol_q  <= wdata_i[1];
          mode_q <= wdata_i[0];
        end
        if (!wdata_i[8])
          shdn_q <= 1'b0;
        else if (!locked)
          shdn_q <= 1'b1;
        if (!(alk_q && wdata_i[2]))
          conly_q <= wdata_i[2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      cr_q  <= '0;
      smp_q <= '0;
    end else begin
      if (wr_hi) hi_q <= wdata_i[12:2];
      if (wr_lo) lo_q <= wdata_i[12:2];
      if (wr_cr) cr_q <= wdata_i[12:2];
      if (sample_vld_i && !shdn_q) smp_q <= sample_i;
    end
  end

  assign hi_lim_o   = {3'b000, hi_q, 2'b00};
  assign lo_lim_o   = {3'b000, lo_q, 2'b00};
  assign crit_lim_o = {3'b000, cr_q, 2'b00};

  assign hyst_o       = hyst_q;
  assign shdn_o       = shdn_q;
  assign crit_lock_o  = clk_q;
  assign alarm_lock_o = alk_q;
  assign clr_evt_o    = clr_q;
  assign evt_oe_o     = oe_q;
  assign crit_only_o  = conly_q;
  assign evt_pol_o    = pol_q;
  assign irq_mode_o   = mode_q;

  always_comb begin
    unique case (addr_i)
      3'd0: rdata_o = CAP_VAL;
      3'd1: rdata_o = {5'b0, hyst_q, shdn_q, clk_q, alk_q, 1'b0,
                       evt_status_i, oe_q, conly_q, pol_q, mode_q};
      3'd2: rdata_o = hi_lim_o;
      3'd3: rdata_o = lo_lim_o;
      3'd4: rdata_o = crit_lim_o;
      3'd5: rdata_o = {trip_i, smp_q};
      3'd6: rdata_o = MFR_VAL;
      default: rdata_o = DEV_VAL;
    endcase
  end

  // R6
  crit_lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crit_lock_o |=> crit_lock_o);
  // R6
  alarm_lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_lock_o |=> alarm_lock_o);
  // R7
  hi_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_lock_o |=> $stable(hi_lim_o) && $stable(lo_lim_o));
  // R7
  crit_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crit_lock_o |=> $stable(crit_lim_o));
  // R9
  no_shdn_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (crit_lock_o || alarm_lock_o) |=> !$rose(shdn_o));
  // R10
  no_conly_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_lock_o |=> !$rose(crit_only_o));
  // R11
  smp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_o |=> $stable(smp_q));
endmodule

// File: tb/tsense_regbank_tb_top.sv
module tsense_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        sample_vld_i = 1'b0;
  logic [12:0] sample_i = '0;
  logic [2:0]  trip_i = '0;
  logic        evt_status_i = 1'b0;
  logic [1:0]  hyst_o;
  logic        shdn_o, crit_lock_o, alarm_lock_o, clr_evt_o, evt_oe_o;
  logic        crit_only_o, evt_pol_o, irq_mode_o;
  logic [15:0] hi_lim_o, lo_lim_o, crit_lim_o;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tsense_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .sample_vld_i(sample_vld_i),
    .sample_i(sample_i), .trip_i(trip_i), .evt_status_i(evt_status_i),
    .hyst_o(hyst_o), .shdn_o(shdn_o), .crit_lock_o(crit_lock_o),
    .alarm_lock_o(alarm_lock_o), .clr_evt_o(clr_evt_o), .evt_oe_o(evt_oe_o),
    .crit_only_o(crit_only_o), .evt_pol_o(evt_pol_o), .irq_mode_o(irq_mode_o),
    .hi_lim_o(hi_lim_o), .lo_lim_o(lo_lim_o), .crit_lim_o(crit_lim_o));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [15:0] exp);
    @(negedge clk);
    addr_i = a;
    #2;
    chk(req, rdata_o, exp);
  endtask

  task automatic smp(input logic [12:0] s);
    @(negedge clk);
    sample_vld_i = 1'b1; sample_i = s;
    @(negedge clk);
    sample_vld_i = 1'b0;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    do_reset();
    rd("R1", 3'd0, 16'h005F);
    rd("R1", 3'd1, 16'h0000);
    rd("R1", 3'd2, 16'h0000);
    rd("R1", 3'd3, 16'h0000);
    rd("R1", 3'd4, 16'h0000);
    rd("R1", 3'd5, 16'h0000);
    rd("R1", 3'd6, 16'h1B09);
    rd("R1", 3'd7, 16'h0812);
  endtask

  task automatic t_readonly;
    wr(3'd0, 16'hFFFF);
    wr(3'd5, 16'hFFFF);
    wr(3'd6, 16'h0000);
    wr(3'd7, 16'hFFFF);
    rd("R2", 3'd0, 16'h005F);
    rd("R2", 3'd5, 16'h0000);
    rd("R2", 3'd6, 16'h1B09);
    rd("R2", 3'd7, 16'h0812);
  endtask

  task automatic t_limits;
    wr(3'd2, 16'hFFFF);
    wr(3'd3, 16'h8003);
    wr(3'd4, 16'h0B57);
    rd("R5", 3'd2, 16'h1FFC);
    rd("R5", 3'd3, 16'h0000);
    rd("R5", 3'd4, 16'h0B54);
    chk("R5", hi_lim_o, 16'h1FFC);
  endtask

  task automatic t_config;
    wr(3'd1, 16'hF63F);
    chk("R4", {15'b0, clr_evt_o}, 16'h0001);
    @(negedge clk);
    chk("R4", {15'b0, clr_evt_o}, 16'h0000);
    rd("R3", 3'd1, 16'h060F);
    evt_status_i = 1'b1;
    rd("R3", 3'd1, 16'h061F);
    evt_status_i = 1'b0;
    chk("R12", {9'b0, hyst_o, shdn_o, evt_oe_o, crit_only_o, evt_pol_o, irq_mode_o},
        16'h006F);
  endtask

  task automatic t_sample;
    trip_i = 3'b101;
    smp(13'h1C90);
    rd("R11", 3'd5, 16'hBC90);
    wr(3'd1, 16'h070F);
    smp(13'h0190);
    rd("R11", 3'd5, 16'hBC90);
    wr(3'd1, 16'h060F);
    trip_i = 3'b010;
    smp(13'h0190);
    rd("R11", 3'd5, 16'h4190);
    trip_i = 3'b000;
  endtask

  task automatic t_locks;
    wr(3'd1, 16'h0040);
    rd("R6", 3'd1, 16'h0040);
    wr(3'd2, 16'h0100);
    rd("R7", 3'd2, 16'h1FFC);
    wr(3'd3, 16'h0100);
    rd("R7", 3'd3, 16'h0000);
    wr(3'd4, 16'h0200);
    rd("R7", 3'd4, 16'h0200);
    wr(3'd1, 16'h064B);
    rd("R8", 3'd1, 16'h0040);
    wr(3'd1, 16'h0140);
    rd("R9", 3'd1, 16'h0040);
    wr(3'd1, 16'h0044);
    rd("R10", 3'd1, 16'h0040);
    wr(3'd1, 16'h0000);
    rd("R6", 3'd1, 16'h0040);
    wr(3'd1, 16'h0080);
    rd("R6", 3'd1, 16'h00C0);
    wr(3'd4, 16'h0300);
    rd("R7", 3'd4, 16'h0200);
  endtask

  task automatic t_shdn_clear;
    do_reset();
    wr(3'd1, 16'h0100);
    wr(3'd1, 16'h0180);
    rd("R9", 3'd1, 16'h0180);
    wr(3'd1, 16'h0080);
    rd("R9", 3'd1, 16'h0080);
    do_reset();
    rd("R6", 3'd1, 16'h0000);
    wr(3'd1, 16'h0004);
    rd("R10", 3'd1, 16'h0004);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_readonly();
    t_limits();
    t_config();
    t_sample();
    t_locks();
    t_shdn_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule